// File: doc/BRIEF.md
# Prescaled Event Timer with Compare Channels

This block keeps a free-running 24-bit time count that advances once per prescaled tick. Four compare channels watch that count. Each one raises a sticky status flag when the count steps onto its compare value, provided the channel is enabled. Unmasked flags pull down a shared active-low interrupt line. Channel 2 also emits a one-cycle pulse that tells a receive sequencer to abandon the frame in progress. Channel 1 emits a one-cycle pulse that starts a transceiver sequence, and it can be narrowed to a 16-bit compare for relative scheduling.

The host reaches the block through a byte-wide register port with a write strobe and a read strobe. The current time is written a byte at a time. The counter changes only when the top byte lands, so the load is atomic. A receive-frame event input latches the live count into a read-only timestamp. The block has no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure. A read strobe always returns data on the next cycle, and a write strobe always takes effect at its edge.

Top module: `evt_timer`

## Requirements
- R1: After reset the count, prescale, compare, control, mode, timestamp and status registers are all zero, `irq_n` is 1, and both pulse outputs are 0.
- R2: With prescale value P (address 0x00), the count advances by one every P+1 clocks. A load of the time restarts that phase, so the first increment follows the load by P+1 clocks.
- R3: The time is written at 0x01 (bits 7:0), 0x02 (bits 15:8) and 0x03 (bits 23:16). Writing 0x01 or 0x02 only stages bytes and leaves the count unchanged. Writing 0x03 loads all 24 bits at once. The count wraps from 0xFFFFFF to 0.
- R4: Channel n has its compare value at 0x08+4n (bits 7:0), 0x09+4n (bits 15:8) and 0x0A+4n (bits 23:16). Its status flag sets at the edge where a counting step makes the count equal to that value, across wrap as well. A host load that makes the count equal to the value does not set the flag.
- R5: A channel whose enable bit (bit n of 0x18) is 0 never sets its flag.
- R6: When bit 0 of the mode register 0x1A is 1, channel 1 compares only bits 15:0. When it is 0, channel 1 compares all 24 bits.
- R7: A channel 2 match drives `rx_abort_pulse` high for exactly one cycle, starting at the same edge that sets flag 2.
- R8: A channel 1 match drives `seq_trigger_pulse` high for exactly one cycle, starting at the same edge that sets flag 1.
- R9: Flags are read at 0x19 (bit n = channel n). Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged. A match in the same cycle as a clear wins.
- R10: `irq_n` is 0 exactly when some flag is set whose mask bit (bit 4+n of 0x18) is 0.
- R11: A high `rx_frame_evt` latches the count held in that cycle into the timestamp, read at 0x04, 0x05 and 0x06 (low to high). The timestamp holds until the next event.
- R12: A read strobe captures the addressed byte into `rd_data` at its edge, and `rd_data` holds it until the next strobe. Time reads return the live count. Compare, control, mode and prescale reads return the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Read data, valid the cycle after the strobe |
| rx_frame_evt | input | 1 | Receive-frame event; latches the timestamp |
| irq_n | output | 1 | Active-low combined interrupt |
| status_flags | output | 4 | Per-channel status flags |
| rx_abort_pulse | output | 1 | One-cycle receive-abort pulse from channel 2 |
| seq_trigger_pulse | output | 1 | One-cycle sequence-start pulse from channel 1 |

## Verification
The bench targets compares that only a carry or a wrap can reach. A design that compared a stale or unincremented count would miss 0x7FFFFC to 0x800002 and 0xFFFFFC to 0x000001. It also checks that a host load landing exactly on a compare value stays silent, and that the narrow mode of channel 1 matches on the low 16 bits alone; a full-width compare there would drop the trigger pulse. Staged time bytes must not disturb the running count, since a non-atomic load would show a torn value. A clear must hit only the bits written as 1, and a masked flag must leave the interrupt line high while still being readable.

// File: rtl/et_pkg.sv
package et_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_PRESCALE = 6'h00;
  localparam logic [ADDR_W-1:0] A_TIME0    = 6'h01;
  localparam logic [ADDR_W-1:0] A_TS0      = 6'h04;
  localparam logic [ADDR_W-1:0] A_CMP_BASE = 6'h08;
  localparam int               CMP_STRIDE = 4;
  localparam logic [ADDR_W-1:0] A_CTRL     = 6'h18;
  localparam logic [ADDR_W-1:0] A_STATUS   = 6'h19;
  localparam logic [ADDR_W-1:0] A_MODE     = 6'h1A;
endpackage

// File: rtl/et_tick_gen.sv
module et_tick_gen #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;

  assign tick = (phase_q >= prescale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (tick)    phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end

  // R2: with a nonzero prescale, ticks never come back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (prescale == '0 || !tick));
endmodule

// File: rtl/et_compare_chan.sv
module et_compare_chan #(
  parameter int CNT_W      = 24,
  parameter int NARROW_W   = 16,
  parameter bit CAN_NARROW = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] next_count,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             en,
  input  logic             narrow,
  input  logic             clr,
  output logic             flag,
  output logic             hit_q
);
  logic eq;
  logic hit;

  generate
    if (CAN_NARROW) begin : g_narrow
      assign eq = narrow ? (next_count[NARROW_W-1:0] == cmp_val[NARROW_W-1:0])
                         : (next_count == cmp_val);
    end else begin : g_full
      assign eq = (next_count == cmp_val);
    end
  endgenerate

  assign hit = step & en & eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit;
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R5: a flag can only rise while the channel is enabled
  a_r5_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(en));
  // R9: a clear with no counting step leaves the flag low
  a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && !$past(step)) |-> !flag);
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int CNT_W     = 24,
  parameter int NUM_CH    = 4,
  parameter int NARROW_W  = 16,
  parameter int PRE_W     = 8,
  parameter int ABORT_CH  = 2,
  parameter int TRIG_CH   = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  input  logic [5:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic        rx_frame_evt,
  output logic        irq_n,
  output logic [3:0]  status_flags,
  output logic        rx_abort_pulse,
  output logic        seq_trigger_pulse
);
  import et_pkg::*;

  localparam int NBYTES  = CNT_W / 8;
  localparam int STAGE_W = CNT_W - 8;
  localparam logic [ADDR_W-1:0] A_TIME_TOP = A_TIME0 + ADDR_W'(NBYTES - 1);

  logic [PRE_W-1:0]   prescale_q;
  logic [STAGE_W-1:0] stage_q;
  logic [CNT_W-1:0]   count_q;
  logic [CNT_W-1:0]   next_count;
  logic [CNT_W-1:0]   ts_q;
  logic [CNT_W-1:0]   cmp_q [NUM_CH];
  logic [NUM_CH-1:0]  en_q;
  logic [NUM_CH-1:0]  mask_q;
  logic               narrow_q;
  logic [7:0]         rd_q;
  logic [7:0]         rd_mux;
  logic               load;
  logic               tick;
  logic               step;
  logic [NUM_CH-1:0]  clr_bits;
  logic [NUM_CH-1:0]  flags;
  logic [NUM_CH-1:0]  hits;

  assign load       = wr_en && (wr_addr == A_TIME_TOP);
  assign step       = tick && !load;
  assign next_count = count_q + 1'b1;
  assign clr_bits   = (wr_en && wr_addr == A_STATUS) ? wr_data[NUM_CH-1:0] : '0;

  et_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (load),
    .prescale (prescale_q),
    .tick     (tick)
  );

  // Time counter: atomic load on the top byte, otherwise prescaled stepping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (load)   count_q <= {wr_data, stage_q};
    else if (tick)   count_q <= next_count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else if (rx_frame_evt) ts_q <= count_q;
  end

  // Host-writable configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescale_q <= '0;
      stage_q    <= '0;
      en_q       <= '0;
      mask_q     <= '0;
      narrow_q   <= 1'b0;
      for (int c = 0; c < NUM_CH; c++) cmp_q[c] <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_PRESCALE) prescale_q <= wr_data[PRE_W-1:0];
      for (int b = 0; b < NBYTES - 1; b++)
        if (wr_addr == A_TIME0 + ADDR_W'(b)) stage_q[8*b +: 8] <= wr_data;
      for (int c = 0; c < NUM_CH; c++)
        for (int b = 0; b < NBYTES; b++)
          if (wr_addr == A_CMP_BASE + ADDR_W'(CMP_STRIDE * c + b))
            cmp_q[c][8*b +: 8] <= wr_data;
      if (wr_addr == A_CTRL) begin
        en_q   <= wr_data[NUM_CH-1:0];
        mask_q <= wr_data[4 +: NUM_CH];
      end
      if (wr_addr == A_MODE) narrow_q <= wr_data[0];
    end
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      et_compare_chan #(
        .CNT_W      (CNT_W),
        .NARROW_W   (NARROW_W),
        .CAN_NARROW (c == TRIG_CH)
      ) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .next_count (next_count),
        .cmp_val    (cmp_q[c]),
        .en         (en_q[c]),
        .narrow     (narrow_q),
        .clr        (clr_bits[c]),
        .flag       (flags[c]),
        .hit_q      (hits[c])
      );
    end
  endgenerate

  // Read path
  always_comb begin
    rd_mux = '0;
    if (rd_addr == A_PRESCALE) rd_mux[PRE_W-1:0] = prescale_q;
    for (int b = 0; b < NBYTES; b++) begin
      if (rd_addr == A_TIME0 + ADDR_W'(b)) rd_mux = count_q[8*b +: 8];
      if (rd_addr == A_TS0 + ADDR_W'(b))   rd_mux = ts_q[8*b +: 8];
    end
    for (int c = 0; c < NUM_CH; c++)
      for (int b = 0; b < NBYTES; b++)
        if (rd_addr == A_CMP_BASE + ADDR_W'(CMP_STRIDE * c + b))
          rd_mux = cmp_q[c][8*b +: 8];
    if (rd_addr == A_CTRL) begin
      rd_mux[NUM_CH-1:0]  = en_q;
      rd_mux[4 +: NUM_CH] = mask_q;
    end
    if (rd_addr == A_STATUS) rd_mux[NUM_CH-1:0] = flags;
    if (rd_addr == A_MODE)   rd_mux[0] = narrow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data           = rd_q;
  assign status_flags      = flags;
  assign irq_n             = ~|(flags & ~mask_q);
  assign rx_abort_pulse    = hits[ABORT_CH];
  assign seq_trigger_pulse = hits[TRIG_CH];

  // R2: without a load or tick the count holds
  a_r2_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && !$past(tick)) |-> $stable(count_q));
  // R7: an abort pulse always comes with its flag
  a_r7_abort_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort_pulse |-> status_flags[ABORT_CH]);
  // R8: a trigger pulse always comes with its flag
  a_r8_trig_flag: assert property (@(posedge clk) disable iff (!rst_n)
    seq_trigger_pulse |-> status_flags[TRIG_CH]);
  // R8: the trigger pulse lasts a single cycle
  a_r8_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_trigger_pulse |=> !seq_trigger_pulse);
  // R10: no flags means no interrupt
  a_r10_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (status_flags == '0) |-> irq_n);
  // R11: the timestamp copies the count seen with the event
  a_r11_ts_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_frame_evt) |-> (ts_q == $past(count_q)));
endmodule

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_PRE = 6'h00, A_T0 = 6'h01, A_T1 = 6'h02, A_T2 = 6'h03;
  localparam logic [5:0] A_S0 = 6'h04, A_S1 = 6'h05, A_S2 = 6'h06;
  localparam logic [5:0] A_CMPB = 6'h08, A_CT = 6'h18, A_ST = 6'h19, A_MD = 6'h1A;

  typedef struct packed {
    logic [1:0]  ch;
    logic        narrow;
    logic [23:0] load;
    logic [23:0] cmp;
    logic        exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 24'h000100, 24'h000105, 1'b1},  // R4 plain
    '{2'd3, 1'b0, 24'h7FFFFC, 24'h800002, 1'b1},  // R4 carry into top byte
    '{2'd2, 1'b0, 24'hFFFFFC, 24'h000001, 1'b1},  // R4/R3 wrap, R7 abort
    '{2'd1, 1'b0, 24'h12000C, 24'hAB0010, 1'b0},  // R6 full width misses
    '{2'd1, 1'b1, 24'h12000C, 24'hAB0010, 1'b1},  // R6 narrow hits, R8
    '{2'd0, 1'b0, 24'h000200, 24'h0001FF, 1'b0},  // R4 behind count
    '{2'd3, 1'b0, 24'h345678, 24'h345678, 1'b0},  // R4 load equal only
    '{2'd2, 1'b0, 24'h00FF00, 24'h01FF05, 1'b0}   // R4 top byte differs
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic rx_frame_evt = 1'b0;
  logic irq_n;
  logic [3:0] status_flags;
  logic rx_abort_pulse;
  logic seq_trigger_pulse;

  int checks = 0;
  int failures = 0;
  int abort_cnt = 0;
  int trig_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rx_frame_evt(rx_frame_evt), .irq_n(irq_n), .status_flags(status_flags),
    .rx_abort_pulse(rx_abort_pulse), .seq_trigger_pulse(seq_trigger_pulse)
  );

  always @(negedge clk) begin
    if (rx_abort_pulse)    abort_cnt++;
    if (seq_trigger_pulse) trig_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic load_time(input logic [23:0] t);
    wr(A_T0, t[7:0]);
    wr(A_T1, t[15:8]);
    wr(A_T2, t[23:16]);
  endtask

  task automatic wr_cmp(input int ch, input logic [23:0] v);
    for (int b = 0; b < 3; b++) wr(A_CMPB + 6'(4*ch + b), v[8*b +: 8]);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    int ab0, tg0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 irq_n", irq_n, 1);
    check("R1 flags", status_flags, 0);
    check("R1 pulses", {rx_abort_pulse, seq_trigger_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_PRE, d); check("R1/R12 prescale", d, 0);
    rd(A_CT, d);  check("R1/R12 ctrl", d, 0);
    rd(A_ST, d);  check("R1 status", d, 0);
    rd(A_S0, d);  check("R1 timestamp", d, 0);

    // Vector table: R4 R6 R7 R8 R3
    for (int i = 0; i < NV; i++) begin
      wr(A_CT, 8'h00);
      wr(A_MD, {7'd0, VECS[i].narrow});
      wr_cmp(VECS[i].ch, VECS[i].cmp);
      load_time(VECS[i].load);
      wr(A_ST, 8'h0F);
      ab0 = abort_cnt; tg0 = trig_cnt;
      wr(A_CT, 8'(1 << VECS[i].ch));
      repeat (12) @(negedge clk);
      rd(A_ST, d);
      check($sformatf("R4 vec%0d status", i), d, 32'(VECS[i].exp) << VECS[i].ch);
      check($sformatf("R10 vec%0d irq_n", i), irq_n, !VECS[i].exp);
      check($sformatf("R7 vec%0d abort", i), abort_cnt - ab0,
            (VECS[i].ch == 2 && VECS[i].exp) ? 1 : 0);
      check($sformatf("R8 vec%0d trigger", i), trig_cnt - tg0,
            (VECS[i].ch == 1 && VECS[i].exp) ? 1 : 0);
    end
    rd(A_CMPB + 6'd10, d); check("R12 cmp2 top byte", d, 8'h01);
    rd(A_MD, d); check("R12 mode readback", d, 8'h00);

    // R5 disabled channel
    wr(A_CT, 8'h00); wr(A_MD, 8'h00);
    wr_cmp(0, 24'h000050);
    load_time(24'h00004C);
    wr(A_ST, 8'h0F);
    repeat (12) @(negedge clk);
    rd(A_ST, d); check("R5 disabled flag", d, 0);
    check("R5 irq_n", irq_n, 1);

    // R9 / R10 clear and mask
    wr_cmp(0, 24'h000105);
    wr_cmp(3, 24'h000106);
    wr(A_CT, 8'h89);
    load_time(24'h000100);
    wr(A_ST, 8'h0F);
    repeat (12) @(negedge clk);
    rd(A_ST, d); check("R9 both flags", d, 8'h09);
    check("R10 unmasked irq", irq_n, 0);
    wr(A_ST, 8'h01);
    rd(A_ST, d); check("R9 selective clear", d, 8'h08);
    check("R10 masked flag no irq", irq_n, 1);
    wr(A_CT, 8'h09);
    @(negedge clk);
    check("R10 unmask asserts", irq_n, 0);
    wr(A_ST, 8'h00);
    rd(A_ST, d); check("R9 zero write no effect", d, 8'h08);
    wr(A_ST, 8'h08);
    rd(A_ST, d); check("R9 last clear", d, 8'h00);
    check("R10 irq released", irq_n, 1);
    wr(A_CT, 8'h00);

    // R3 atomic load
    wr(A_PRE, 8'hFF);
    load_time(24'h123456);
    wr(A_T0, 8'hAA);
    wr(A_T1, 8'hBB);
    rd(A_T0, d); check("R3 low after staging", d, 8'h56);
    rd(A_T1, d); check("R3 mid after staging", d, 8'h34);
    rd(A_T2, d); check("R3 top after staging", d, 8'h12);

    // R2 prescale P=3: read 21 edges after load gives T+5
    wr(A_PRE, 8'h03);
    load_time(24'h000010);
    repeat (20) @(negedge clk);
    rd(A_T0, d); check("R2 prescaled count", d, 8'h15);

    // R11 timestamp
    wr(A_PRE, 8'h00);
    load_time(24'h00ABCD);
    rx_frame_evt = 1'b1;
    @(negedge clk);
    rx_frame_evt = 1'b0;
    repeat (5) @(negedge clk);
    rd(A_S0, d); check("R11 ts low", d, 8'hCD);
    rd(A_S1, d); check("R11 ts mid", d, 8'hAB);
    rd(A_S2, d); check("R11 ts top", d, 8'h00);
    repeat (10) @(negedge clk);
    rd(A_S0, d); check("R11 ts holds", d, 8'hCD);

    done = 1'b1;
    finish_run();
  end
endmodule